// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block runs the refill of one data cache line after a load has missed. It reads the line from memory as eight 64-bit reads over a pipelined Wishbone master port. The first read is the dword the load asked for. The following reads step through the rest of the line, wrapping from the last dword back to the first. Each returned dword is written into a data RAM that is one dword wide. The row index of that write is the set index followed by the dword offset, so a line occupies consecutive rows. The dword the load wanted is also forwarded straight to the load result port. The load does not wait for the RAM write.

A bit per dword records which parts of the line have arrived. While the refill runs, the block accepts one more load to the same line. That load completes as soon as its dword is present, not when the whole line is done. A load to any other line is held off until the refill ends, because only one refill can be in progress. After the last acknowledge, the block writes the tag into the way chosen by the requester and marks the line valid. A bus error ends the refill early: the tag entry is written as invalid and any load still waiting is returned with an error.

Top module: `cwf_refill`

## Requirements
- R1: After reset: `ld_ready` is 1, and `wb_cyc`, `wb_stb`, `ld_done`, `ram_we` and `tag_we` are 0.
- R2: A load accepted while idle (`ld_valid` and `ld_ready` at a clock edge) starts a refill. In the next cycle, `wb_cyc` and `wb_stb` are 1 and `wb_adr` equals that load's dword address `ld_adr`.
- R3: Bus requests keep the line bits of `wb_adr` (bits above the low 3) fixed. The low 3 bits step by one, modulo 8, after every cycle with `wb_stb` high and `wb_stall` low. While `wb_stall` is high, `wb_adr` and `wb_stb` hold. After exactly 8 accepted requests, `wb_stb` is 0.
- R4: In the cycle after each acknowledge, `ram_we` is 1 with `ram_wdata` equal to the returned data and `ram_way` equal to the refill way. `ram_row` is {set index = `ld_adr`[8:3], dword offset}. For the k-th acknowledge (counting from 0), the dword offset is (critical offset + k) mod 8. At no other time is `ram_we` 1.
- R5: The load that started the refill sees `ld_done` = 1 and `ld_err` = 0 in the cycle after its own dword is acknowledged. `ld_data` carries the returned data.
- R6: During a refill, `ld_ready` is 1 only when three things hold: `ld_adr`[28:3] equals the refilling line, no load is waiting, and `wb_err` is low. Otherwise it is 0. While idle it is 1.
- R7: A load accepted during a refill whose dword has already arrived (or is acknowledged in the same cycle) completes in the next cycle with that dword's data.
- R8: A load accepted during a refill whose dword has not yet arrived completes in the cycle after that dword's acknowledge, with that data.
- R9: In the cycle after the eighth acknowledge, `wb_cyc` is 0 and `tag_we` pulses with `tag_valid` = 1. At the same time, `tag_index` is the set index, `tag_value` is the line address bits above the set index, and `tag_way` is the refill way. `wb_cyc` is 1 from the start of a refill until then.
- R10: `wb_err` with `wb_cyc` high drops `wb_cyc` and `wb_stb` in the next cycle. In that same cycle, `tag_we` pulses with `tag_valid` = 0. If a load was waiting, it sees `ld_done` = 1 with `ld_err` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load that missed the cache is presented |
| ld_adr | input | 29 | Dword address of the load: {tag, set index[5:0], offset[2:0]} |
| ld_way | input | 2 | Way to fill for a new refill |
| ld_ready | output | 1 | Load is taken at this edge when `ld_valid` is high |
| ld_done | output | 1 | One-cycle completion pulse |
| ld_err | output | 1 | Completion carries a bus error |
| ld_data | output | 64 | Load result |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Read request strobe |
| wb_adr | output | 29 | Dword address of the request |
| wb_stall | input | 1 | Slave cannot take a request this cycle |
| wb_ack | input | 1 | Read data valid |
| wb_err | input | 1 | Bus error |
| wb_dat_i | input | 64 | Read data |
| ram_we | output | 1 | Data RAM write strobe |
| ram_way | output | 2 | Data RAM way |
| ram_row | output | 9 | Data RAM row {set index, dword offset} |
| ram_wdata | output | 64 | Data RAM write data |
| tag_we | output | 1 | Tag RAM write strobe |
| tag_way | output | 2 | Tag RAM way |
| tag_index | output | 6 | Tag RAM set index |
| tag_value | output | 20 | Tag written |
| tag_valid | output | 1 | Line-valid bit written |

## Verification
All results are registered, so each one appears exactly one cycle after the clock edge that caused it:
- the first bus request, one cycle after the load that missed is accepted;
- each RAM write and each forwarded completion, one cycle after the acknowledge;
- the tag write and the drop of `wb_cyc`, one cycle after the final acknowledge or the error;
- a completion from already-received data, one cycle after the load is accepted.

The only result that is not registered is `ld_ready`, which is combinational in the same cycle.

The bench records, just before each rising edge, which handshakes, acknowledges and errors took place. At the next falling edge it turns those events into expected values and compares them with the outputs, so every comparison lands in the one cycle where the result is due. The bench checks `ld_ready` shortly after it drives the inputs, within the same cycle.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_st_e;
endpackage

// File: rtl/cwf_bus_seq.sv
// Issues the eight reads of a line in wrap order and tracks the returns.
module cwf_bus_seq #(
    parameter int OFF_W   = 3,
    parameter int LINE_AW = 26,
    localparam int BEATS  = 1 << OFF_W,
    localparam int CNT_W  = OFF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [LINE_AW-1:0]       start_line,
    input  logic [OFF_W-1:0]         start_off,
    input  logic                     wb_stall,
    input  logic                     wb_ack,
    input  logic                     wb_err,
    output logic                     wb_cyc,
    output logic                     wb_stb,
    output logic [LINE_AW+OFF_W-1:0] wb_adr,
    output logic                     beat_valid,
    output logic [OFF_W-1:0]         beat_off,
    output logic                     beat_last,
    output logic                     bus_err
);
    typedef struct packed {
        logic               cyc;
        logic               stb;
        logic [LINE_AW-1:0] line;
        logic [OFF_W-1:0]   iss_off;
        logic [CNT_W-1:0]   iss_cnt;
        logic [OFF_W-1:0]   ret_off;
        logic [CNT_W-1:0]   ret_cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    assign wb_cyc     = seq_q.cyc;
    assign wb_stb     = seq_q.stb;
    assign wb_adr     = {seq_q.line, seq_q.iss_off};
    assign bus_err    = seq_q.cyc & wb_err;
    assign beat_valid = seq_q.cyc & wb_ack & ~wb_err;
    assign beat_off   = seq_q.ret_off;
    assign beat_last  = beat_valid && (seq_q.ret_cnt == CNT_W'(BEATS - 1));

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.cyc     = 1'b1;
            seq_d.stb     = 1'b1;
            seq_d.line    = start_line;
            seq_d.iss_off = start_off;
            seq_d.ret_off = start_off;
            seq_d.iss_cnt = '0;
            seq_d.ret_cnt = '0;
        end else if (seq_q.cyc) begin
            if (seq_q.stb && !wb_stall) begin
                seq_d.iss_off = seq_q.iss_off + 1'b1;
                seq_d.iss_cnt = seq_q.iss_cnt + 1'b1;
                if (seq_q.iss_cnt == CNT_W'(BEATS - 1)) begin
                    seq_d.stb = 1'b0;
                end
            end
            if (beat_valid) begin
                seq_d.ret_off = seq_q.ret_off + 1'b1;
                seq_d.ret_cnt = seq_q.ret_cnt + 1'b1;
            end
            if (beat_last || bus_err) begin
                seq_d.cyc = 1'b0;
                seq_d.stb = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/cwf_line_buf.sv
// One slot per dword of the line being refilled: arrival bit plus a data copy.
module cwf_line_buf #(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 3,
    localparam int SLOTS = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data
);
    logic [SLOTS-1:0]             have_vec;
    logic [SLOTS-1:0][DATA_W-1:0] word_vec;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic              have_d, have_q;
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            have_d = have_q;
            word_d = word_q;
            if (clear) begin
                have_d = 1'b0;
            end else if (wr_en && (wr_off == OFF_W'(s))) begin
                have_d = 1'b1;
                word_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                have_q <= 1'b0;
                word_q <= '0;
            end else begin
                have_q <= have_d;
                word_q <= word_d;
            end
        end

        assign have_vec[s] = have_q;
        assign word_vec[s] = word_q;
    end

    assign rd_hit  = have_vec[rd_off];
    assign rd_data = word_vec[rd_off];
endmodule

// File: rtl/cwf_refill.sv
module cwf_refill
    import cwf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int LINE_DWORDS = 8,
    parameter int SETS        = 64,
    parameter int WAYS        = 4,
    localparam int BYTE_W  = $clog2(DATA_W / 8),
    localparam int OFF_W   = $clog2(LINE_DWORDS),
    localparam int IDX_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int WADR_W  = ADDR_W - BYTE_W,
    localparam int LINE_AW = WADR_W - OFF_W,
    localparam int TAG_W   = LINE_AW - IDX_W,
    localparam int ROW_W   = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [WADR_W-1:0] ld_adr,
    input  logic [WAY_W-1:0]  ld_way,
    output logic              ld_ready,
    output logic              ld_done,
    output logic              ld_err,
    output logic [DATA_W-1:0] ld_data,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic [WADR_W-1:0] wb_adr,
    input  logic              wb_stall,
    input  logic              wb_ack,
    input  logic              wb_err,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic              ram_we,
    output logic [WAY_W-1:0]  ram_way,
    output logic [ROW_W-1:0]  ram_row,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              tag_we,
    output logic [WAY_W-1:0]  tag_way,
    output logic [IDX_W-1:0]  tag_index,
    output logic [TAG_W-1:0]  tag_value,
    output logic              tag_valid
);
    typedef struct packed {
        fill_st_e           st;
        logic [LINE_AW-1:0] line;
        logic [WAY_W-1:0]   way;
        logic               pend;
        logic [OFF_W-1:0]   pend_off;
        logic               done;
        logic               err;
        logic [DATA_W-1:0]  data;
        logic               ram_we;
        logic [OFF_W-1:0]   ram_off;
        logic [DATA_W-1:0]  ram_data;
        logic               tag_we;
        logic               tag_ok;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LINE_AW-1:0] req_line;
    logic [OFF_W-1:0]   req_off;
    logic               same_line, accept, start;
    logic               beat_valid, beat_last, bus_err;
    logic [OFF_W-1:0]   beat_off;
    logic               buf_hit;
    logic [DATA_W-1:0]  buf_data;

    assign req_line  = ld_adr[WADR_W-1:OFF_W];
    assign req_off   = ld_adr[OFF_W-1:0];
    assign same_line = (req_line == ctl_q.line);
    assign ld_ready  = (ctl_q.st == FILL_IDLE) || (!ctl_q.pend && same_line && !bus_err);
    assign accept    = ld_valid & ld_ready;
    assign start     = accept && (ctl_q.st == FILL_IDLE);

    cwf_bus_seq #(
        .OFF_W  (OFF_W),
        .LINE_AW(LINE_AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_line(req_line),
        .start_off (req_off),
        .wb_stall  (wb_stall),
        .wb_ack    (wb_ack),
        .wb_err    (wb_err),
        .wb_cyc    (wb_cyc),
        .wb_stb    (wb_stb),
        .wb_adr    (wb_adr),
        .beat_valid(beat_valid),
        .beat_off  (beat_off),
        .beat_last (beat_last),
        .bus_err   (bus_err)
    );

    cwf_line_buf #(
        .DATA_W(DATA_W),
        .OFF_W (OFF_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .wr_en  (beat_valid),
        .wr_off (beat_off),
        .wr_data(wb_dat_i),
        .rd_off (req_off),
        .rd_hit (buf_hit),
        .rd_data(buf_data)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done   = 1'b0;
        ctl_d.err    = 1'b0;
        ctl_d.ram_we = 1'b0;
        ctl_d.tag_we = 1'b0;
        case (ctl_q.st)
            FILL_IDLE: begin
                if (accept) begin
                    ctl_d.st       = FILL_RUN;
                    ctl_d.line     = req_line;
                    ctl_d.way      = ld_way;
                    ctl_d.pend     = 1'b1;
                    ctl_d.pend_off = req_off;
                end
            end
            default: begin
                if (beat_valid) begin
                    ctl_d.ram_we   = 1'b1;
                    ctl_d.ram_off  = beat_off;
                    ctl_d.ram_data = wb_dat_i;
                    if (ctl_q.pend && (beat_off == ctl_q.pend_off)) begin
                        ctl_d.done = 1'b1;
                        ctl_d.data = wb_dat_i;
                        ctl_d.pend = 1'b0;
                    end
                end
                // A same-line load joins the refill; accept implies no load waits.
                if (accept) begin
                    if (beat_valid && (beat_off == req_off)) begin
                        ctl_d.done = 1'b1;
                        ctl_d.data = wb_dat_i;
                    end else if (buf_hit) begin
                        ctl_d.done = 1'b1;
                        ctl_d.data = buf_data;
                    end else begin
                        ctl_d.pend     = 1'b1;
                        ctl_d.pend_off = req_off;
                    end
                end
                if (bus_err) begin
                    ctl_d.st     = FILL_IDLE;
                    ctl_d.tag_we = 1'b1;
                    ctl_d.tag_ok = 1'b0;
                    if (ctl_q.pend) begin
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                        ctl_d.pend = 1'b0;
                    end
                end else if (beat_last) begin
                    ctl_d.st     = FILL_IDLE;
                    ctl_d.tag_we = 1'b1;
                    ctl_d.tag_ok = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ld_done   = ctl_q.done;
    assign ld_err    = ctl_q.err;
    assign ld_data   = ctl_q.data;
    assign ram_we    = ctl_q.ram_we;
    assign ram_way   = ctl_q.way;
    assign ram_row   = {ctl_q.line[IDX_W-1:0], ctl_q.ram_off};
    assign ram_wdata = ctl_q.ram_data;
    assign tag_we    = ctl_q.tag_we;
    assign tag_way   = ctl_q.way;
    assign tag_index = ctl_q.line[IDX_W-1:0];
    assign tag_value = ctl_q.line[LINE_AW-1:IDX_W];
    assign tag_valid = ctl_q.tag_ok;
endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
    parameter int WADR_W = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_cyc,
    input logic              wb_stb,
    input logic              wb_stall,
    input logic              wb_ack,
    input logic              wb_err,
    input logic [WADR_W-1:0] wb_adr,
    input logic              ld_done,
    input logic              ld_err,
    input logic              ram_we,
    input logic              tag_we
);
    assert_stb_inside_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> wb_cyc);

    assert_stall_holds_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_stall && !wb_err) |=> (wb_stb && $stable(wb_adr)));

    assert_write_follows_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(wb_ack && wb_cyc));

    assert_tag_closes_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> (!wb_cyc && $past(wb_cyc)));

    assert_error_ends_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_err) |=> (!wb_cyc && tag_we));

    assert_error_is_completion_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_err |-> ld_done);
endmodule

bind cwf_refill cwf_refill_chk #(
    .WADR_W(WADR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_cyc  (wb_cyc),
    .wb_stb  (wb_stb),
    .wb_stall(wb_stall),
    .wb_ack  (wb_ack),
    .wb_err  (wb_err),
    .wb_adr  (wb_adr),
    .ld_done (ld_done),
    .ld_err  (ld_err),
    .ram_we  (ram_we),
    .tag_we  (tag_we)
);

// File: tb/cwf_refill_test.sv
`timescale 1ns/1ps
module cwf_refill_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_valid;
    logic [28:0] ld_adr;
    logic [1:0]  ld_way;
    logic        ld_ready, ld_done, ld_err;
    logic [63:0] ld_data;
    logic        wb_cyc, wb_stb;
    logic [28:0] wb_adr;
    logic        wb_stall, wb_ack, wb_err;
    logic [63:0] wb_dat_i;
    logic        ram_we;
    logic [1:0]  ram_way;
    logic [8:0]  ram_row;
    logic [63:0] ram_wdata;
    logic        tag_we;
    logic [1:0]  tag_way;
    logic [5:0]  tag_index;
    logic [19:0] tag_value;
    logic        tag_valid;

    always #2.5 clk = ~clk;

    cwf_refill uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_adr(ld_adr), .ld_way(ld_way),
        .ld_ready(ld_ready), .ld_done(ld_done), .ld_err(ld_err), .ld_data(ld_data),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_adr(wb_adr), .wb_stall(wb_stall),
        .wb_ack(wb_ack), .wb_err(wb_err), .wb_dat_i(wb_dat_i),
        .ram_we(ram_we), .ram_way(ram_way), .ram_row(ram_row), .ram_wdata(ram_wdata),
        .tag_we(tag_we), .tag_way(tag_way), .tag_index(tag_index), .tag_value(tag_value),
        .tag_valid(tag_valid)
    );

    int n_checks = 0;
    int n_errors = 0;

    function automatic logic [63:0] mem_word(logic [28:0] a);
        return {a, 6'h2d, ~a} ^ 64'h5a3c_0ff0_c3a5_9966;
    endfunction

    task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // bench model of the refill
    bit          fill_act, pend_act, pend_primary;
    logic [25:0] m_line;
    logic [1:0]  m_way;
    logic [2:0]  m_crit, pend_off;
    int          m_issued, m_acks;
    bit [7:0]    got;
    logic [28:0] ackq[$];
    logic [28:0] force_q[$];
    bit          stall_en, err_en;

    // events seen just before the last rising edge
    bit          h_issue, h_ack, h_err, h_accept, h_fill;
    logic [28:0] h_adr, h_la;
    logic [1:0]  h_way;

    function automatic logic [28:0] rand_adr();
        return {20'($urandom % 4), 6'($urandom), 3'($urandom)};
    endfunction

    task automatic step();
        bit          e_done, e_err, e_ram, e_tag, e_tok, e_start;
        logic [63:0] e_data, e_rdata;
        logic [8:0]  e_row;
        string       done_req;
        logic [2:0]  off;
        logic [28:0] a;
        bit          exp_ready;
        @(negedge clk);
        e_done = 0; e_err = 0; e_ram = 0; e_tag = 0; e_tok = 0; e_start = 0;
        e_data = '0; e_rdata = '0; e_row = '0; done_req = "R5";
        if (h_issue) begin
            check_eq("R3 request address", h_adr, {m_line, 3'(m_crit + 3'(m_issued))});
            ackq.push_back(h_adr);
            m_issued++;
        end
        if (h_ack) begin
            a = ackq.pop_front();
            off = a[2:0];
            got[off] = 1'b1;
            check_eq("R4 return order", off, 3'(m_crit + 3'(m_acks)));
            m_acks++;
            e_ram = 1; e_row = {a[8:3], off}; e_rdata = mem_word(a);
            if (pend_act && off == pend_off) begin
                e_done = 1; e_data = mem_word(a); pend_act = 0;
                done_req = pend_primary ? "R5" : "R8";
            end
            if (m_acks == 8) begin
                fill_act = 0; e_tag = 1; e_tok = 1;
            end
        end
        if (h_err) begin
            fill_act = 0; ackq.delete(); e_tag = 1; e_tok = 0;
            if (pend_act) begin
                e_done = 1; e_err = 1; pend_act = 0; done_req = "R10";
            end
        end
        if (h_accept) begin
            if (!h_fill) begin
                fill_act = 1; m_line = h_la[28:3]; m_way = h_way; m_crit = h_la[2:0];
                m_issued = 0; m_acks = 0; got = '0;
                pend_act = 1; pend_primary = 1; pend_off = h_la[2:0]; e_start = 1;
            end else if (got[h_la[2:0]]) begin
                e_done = 1; e_data = mem_word(h_la); done_req = "R7";
            end else begin
                pend_act = 1; pend_primary = 0; pend_off = h_la[2:0];
            end
        end
        // compare outputs due this cycle
        check_eq({done_req, " done"}, ld_done, e_done);
        if (e_done) begin
            check_eq({done_req, " err"}, ld_err, e_err);
            if (!e_err) check_eq({done_req, " data"}, ld_data, e_data);
        end
        check_eq("R4 ram_we", ram_we, e_ram);
        if (e_ram) begin
            check_eq("R4 ram_row", ram_row, e_row);
            check_eq("R4 ram_way", ram_way, m_way);
            check_eq("R4 ram_wdata", ram_wdata, e_rdata);
        end
        check_eq(e_tok ? "R9 tag_we" : "R10 tag_we", tag_we, e_tag);
        if (e_tag) begin
            check_eq("R9 tag_valid", tag_valid, e_tok);
            check_eq("R9 tag_index", tag_index, m_line[5:0]);
            check_eq("R9 tag_value", tag_value, m_line[25:6]);
            check_eq("R9 tag_way", tag_way, m_way);
        end
        if (e_start) check_eq("R2 first address", wb_adr, h_la);
        check_eq("R9 wb_cyc", wb_cyc, fill_act);
        check_eq("R3 wb_stb", wb_stb, fill_act && m_issued < 8);
        // drive next inputs
        wb_stall = stall_en && ($urandom % 3 == 0);
        wb_err = 0; wb_ack = 0; wb_dat_i = '0;
        if (err_en && fill_act && $urandom % 10 == 0) begin
            wb_err = 1;
        end else if (ackq.size() > 0 && $urandom % 4 != 0) begin
            wb_ack = 1; wb_dat_i = mem_word(ackq[0]);
        end
        ld_way = 2'($urandom);
        if (!fill_act) begin
            if (force_q.size() > 0) begin
                ld_valid = 1; ld_adr = force_q.pop_front();
            end else begin
                ld_valid = ($urandom % 10 < 6); ld_adr = rand_adr();
            end
        end else begin
            ld_valid = $urandom % 2;
            ld_adr = ($urandom % 10 < 7) ? {m_line, 3'($urandom)} : rand_adr();
        end
        #1;
        exp_ready = !fill_act || (!pend_act && ld_adr[28:3] == m_line && !wb_err);
        check_eq("R6 ld_ready", ld_ready, exp_ready);
        h_issue = wb_stb && !wb_stall; h_adr = wb_adr;
        h_ack = wb_ack && wb_cyc; h_err = wb_err && wb_cyc;
        h_accept = ld_valid && ld_ready; h_la = ld_adr; h_way = ld_way; h_fill = fill_act;
    endtask

    initial begin
        #(100000 * 5);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        rst_n = 0; ld_valid = 0; ld_adr = '0; ld_way = '0;
        wb_stall = 0; wb_ack = 0; wb_err = 0; wb_dat_i = '0;
        fill_act = 0; pend_act = 0; pend_primary = 0; got = '0; m_line = '0; m_way = '0;
        m_crit = '0; pend_off = '0; m_issued = 0; m_acks = 0;
        h_issue = 0; h_ack = 0; h_err = 0; h_accept = 0; h_fill = 0; h_adr = '0; h_la = '0; h_way = '0;
        stall_en = 0; err_en = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        check_eq("R1 ld_ready", ld_ready, 1'b1);
        check_eq("R1 wb_cyc", wb_cyc, 1'b0);
        check_eq("R1 wb_stb", wb_stb, 1'b0);
        check_eq("R1 ld_done", ld_done, 1'b0);
        check_eq("R1 ram_we", ram_we, 1'b0);
        check_eq("R1 tag_we", tag_we, 1'b0);
        // directed corners: critical dword at the end and at the start of a line
        force_q.push_back({20'h00003, 6'h3f, 3'd7});
        force_q.push_back({20'h00001, 6'h00, 3'd0});
        for (int i = 0; i < 1500; i++) step();
        stall_en = 1;
        force_q.push_back({20'h00002, 6'h15, 3'd7});
        for (int i = 0; i < 1500; i++) step();
        err_en = 1;
        force_q.push_back({20'h00000, 6'h2a, 3'd5});
        for (int i = 0; i < 2000; i++) step();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule